// File: doc/BRIEF.md
# Serial Flash Fast-Read Target

This block is the responding end of a single-bit SPI link inside a serial flash. It decodes the fast-read command: an 8-bit opcode, a 24-bit byte address and one byte of dummy clocks, all taken from the serial input on rising SCLK edges. After that header it sends bytes from a small on-chip array on the serial output. Each bit changes on a falling SCLK edge, most significant bit first. The read address advances after every byte and wraps from the top of the array to zero. A host can therefore read any amount of data with a single command, and releasing chip select ends the transfer at any point.

The SPI pins are sampled by the system clock `clk`, which must run well above the SCLK rate. A `busy` input stands for a program or erase cycle that is already running elsewhere in the device. If `busy` is high when the opcode completes, the command is dropped. A write stream preloads the array. It follows valid/ready rules: `pre_valid` with its address and data must stay stable until `pre_ready` is high at a rising `clk`. `pre_ready` is high only while the target is deselected. Selecting the target therefore stalls any pending preload until chip select goes high again.

Top module: `flash_ft_target`

## Requirements
- R1: After reset with chip select high, `miso_oe` is 0 and `pre_ready` is 1.
- R2: A preload beat transfers when `pre_valid` and `pre_ready` are both high at a rising `clk`, writing `pre_data` at `pre_addr`. `pre_ready` stays low while chip select is low, and no write takes place then.
- R3: A command is opcode 0x0B followed by a 24-bit address, both MSB first and sampled on SCLK rising edges. Only the low `AW` address bits select the starting byte.
- R4: `miso_oe` stays 0 through the 40 SCLK clocks of opcode, address and dummy byte.
- R5: The first data bit (bit 7 of the addressed byte) is driven after the falling SCLK edge that follows the 40th rising edge. The following bits come out MSB first, one per falling edge.
- R6: After 8 bits the next byte follows with the address plus one, without limit.
- R7: After the byte at address 2^AW-1, streaming continues at address 0.
- R8: Chip select high at any time drives `miso_oe` to 0 within 3 `clk` cycles. The next selection starts a new opcode.
- R9: An opcode other than 0x0B keeps `miso_oe` at 0 until chip select goes high.
- R10: `busy` high at the 8th rising SCLK edge makes the target ignore the command. `busy` at any other time has no effect.
- R11: `miso` changes only in the cycle after a detected SCLK falling edge and keeps its value during the SCLK high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, idles low |
| mosi | input | 1 | Serial data from the host |
| busy | input | 1 | High while a program or erase cycle runs |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for `miso`; 0 means high impedance |
| pre_valid | input | 1 | Preload beat valid |
| pre_ready | output | 1 | Preload beat accepted |
| pre_addr | input | AW | Preload byte address |
| pre_data | input | 8 | Preload byte value |

## Verification
Chip-select release and the falling SCLK edge at a byte boundary can land in the same system cycle. That falling edge would otherwise load the next byte and advance the address. Every command in the bench ends by raising `cs_n` and lowering SCLK in the same `clk` cycle, right after the last bit of a byte. The result is judged by `miso_oe` being low three cycles later, and by the next command streaming from its own address with no carry-over from the one that was cut off. One command aborts in the middle of a byte to cover the non-boundary case.

// File: rtl/flash_ft_pkg.sv
package flash_ft_pkg;
  localparam logic [7:0] OPC_FAST   = 8'h0B;
  localparam int         CMD_BITS   = 8;
  localparam int         ADDR_BITS  = 24;
  localparam int         DUMMY_BITS = 8;
  localparam int         HDR_BITS   = CMD_BITS + ADDR_BITS + DUMMY_BITS;

  typedef enum logic [2:0] {
    ST_OPC,
    ST_ADR,
    ST_DMY,
    ST_DAT,
    ST_OFF
  } phase_e;
endpackage

// File: rtl/flash_ft_pins.sv
module flash_ft_pins (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sclk,
  input  logic mosi,
  output logic desel,
  output logic rise,
  output logic fall,
  output logic din
);
  logic s_cs, s_sclk, s_mosi, p_sclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_cs   <= 1'b1;
      s_sclk <= 1'b0;
      s_mosi <= 1'b0;
      p_sclk <= 1'b0;
    end else begin
      s_cs   <= cs_n;
      s_sclk <= sclk;
      s_mosi <= mosi;
      p_sclk <= s_sclk;
    end
  end

  assign desel = s_cs;
  assign rise  = s_sclk & ~p_sclk;
  assign fall  = ~s_sclk & p_sclk;
  assign din   = s_mosi;
endmodule

// File: rtl/flash_ft_array.sv
module flash_ft_array #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/flash_ft_seq.sv
module flash_ft_seq
  import flash_ft_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          desel,
  input  logic          rise,
  input  logic          fall,
  input  logic          din,
  input  logic          busy,
  input  logic [7:0]    rdata,
  output logic [AW-1:0] raddr,
  output logic          miso_o,
  output logic          miso_oe,
  output logic          idle_o
);
  localparam logic [5:0] OPC_END = 6'(CMD_BITS - 1);
  localparam logic [5:0] ADR_END = 6'(CMD_BITS + ADDR_BITS - 1);
  localparam logic [5:0] HDR_END = 6'(HDR_BITS - 1);

  phase_e        ph;
  logic [5:0]    cnt;
  logic [23:0]   shin;
  logic [AW-1:0] ptr;
  logic [7:0]    shout;
  logic [2:0]    left;

  wire [7:0]  opc_now = {shin[6:0], din};
  wire [23:0] adr_now = {shin[22:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= ST_OPC;
      cnt     <= '0;
      shin    <= '0;
      ptr     <= '0;
      shout   <= '0;
      left    <= '0;
      miso_o  <= 1'b0;
      miso_oe <= 1'b0;
      idle_o  <= 1'b1;
    end else begin
      idle_o <= desel;
      if (desel) begin
        ph      <= ST_OPC;
        cnt     <= '0;
        left    <= '0;
        miso_oe <= 1'b0;
      end else begin
        case (ph)
          ST_OPC: if (rise) begin
            shin <= adr_now;
            cnt  <= cnt + 6'd1;
            if (cnt == OPC_END)
              ph <= (opc_now == OPC_FAST && !busy) ? ST_ADR : ST_OFF;
          end
          ST_ADR: if (rise) begin
            shin <= adr_now;
            cnt  <= cnt + 6'd1;
            if (cnt == ADR_END) begin
              ph  <= ST_DMY;
              ptr <= adr_now[AW-1:0];
            end
          end
          ST_DMY: if (rise) begin
            cnt <= cnt + 6'd1;
            if (cnt == HDR_END) ph <= ST_DAT;
          end
          ST_DAT: if (fall) begin
            miso_oe <= 1'b1;
            if (left == 3'd0) begin
              miso_o <= rdata[7];
              shout  <= {rdata[6:0], 1'b0};
              left   <= 3'd7;
              ptr    <= ptr + 1'b1;
            end else begin
              miso_o <= shout[7];
              shout  <= {shout[6:0], 1'b0};
              left   <= left - 3'd1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign raddr = ptr;
endmodule

// File: rtl/flash_ft_target.sv
module flash_ft_target #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic          mosi,
  input  logic          busy,
  output logic          miso,
  output logic          miso_oe,
  input  logic          pre_valid,
  output logic          pre_ready,
  input  logic [AW-1:0] pre_addr,
  input  logic [7:0]    pre_data
);
  logic          w_desel, w_rise, w_fall, w_din, w_idle;
  logic [AW-1:0] w_raddr;
  logic [7:0]    w_rdata;

  flash_ft_pins u_pins (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .sclk  (sclk),
    .mosi  (mosi),
    .desel (w_desel),
    .rise  (w_rise),
    .fall  (w_fall),
    .din   (w_din)
  );

  flash_ft_array #(.AW(AW)) u_array (
    .clk   (clk),
    .we    (pre_valid & w_idle),
    .waddr (pre_addr),
    .wdata (pre_data),
    .raddr (w_raddr),
    .rdata (w_rdata)
  );

  flash_ft_seq #(.AW(AW)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .desel   (w_desel),
    .rise    (w_rise),
    .fall    (w_fall),
    .din     (w_din),
    .busy    (busy),
    .rdata   (w_rdata),
    .raddr   (w_raddr),
    .miso_o  (miso),
    .miso_oe (miso_oe),
    .idle_o  (w_idle)
  );

  assign pre_ready = w_idle;
endmodule

// File: rtl/flash_ft_sva.sv
module flash_ft_sva (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic miso,
  input logic miso_oe,
  input logic pre_ready,
  input logic sclk_fall
);
  assert_release_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ##1 !miso_oe);

  assert_ready_low_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |=> ##1 !pre_ready);

  assert_no_preload_while_driving_R2: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> !pre_ready);

  assert_out_only_after_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_fall |=> $stable(miso));

  assert_enable_follows_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miso_oe) |-> $past(sclk_fall));
endmodule

bind flash_ft_target flash_ft_sva u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .miso      (miso),
  .miso_oe   (miso_oe),
  .pre_ready (pre_ready),
  .sclk_fall (w_fall)
);

// File: tb/test_flash_ft_target.sv
module test_flash_ft_target;
  localparam int AW    = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0, busy = 1'b0;
  logic pre_valid = 1'b0;
  logic [AW-1:0] pre_addr = '0;
  logic [7:0]    pre_data = '0;
  logic miso, miso_oe, pre_ready;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] model [DEPTH];

  flash_ft_target #(.AW(AW)) i_flash_ft_target (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .busy(busy), .miso(miso), .miso_oe(miso_oe), .pre_valid(pre_valid),
    .pre_ready(pre_ready), .pre_addr(pre_addr), .pre_data(pre_data)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pre_write(input int a, input int d);
    pre_valid = 1'b1;
    pre_addr  = AW'(a);
    pre_data  = 8'(d);
    tick(1);
    while (!pre_ready) tick(1);
    pre_valid = 1'b0;
    model[a]  = 8'(d);
  endtask

  // busy_mode: 0 idle, 1 high across the opcode, 2 high from the address onward
  task automatic run_cmd(input logic [7:0] opc, input logic [23:0] adr,
                         input int nbits, input int busy_mode, input string req);
    bit ignore;
    int base;
    ignore = (opc != 8'h0B) || (busy_mode == 1);
    base   = int'(adr[AW-1:0]);
    cs_n = 1'b0;
    tick(2);
    for (int k = 0; k < 40 + nbits; k++) begin
      sclk = 1'b0;
      mosi = (k < 8) ? opc[7-k] : (k < 32) ? adr[31-k] : 1'b0;
      busy = (busy_mode == 1 && k < 8) || (busy_mode == 2 && k >= 8);
      tick(3);
      if (k < 40 || ignore) begin
        // R4 header quiet, R9 bad opcode, R10 busy drop
        chk(k < 40 ? "R4" : req, "miso_oe quiet", int'(miso_oe), 0);
      end else begin
        int j = k - 40;
        int e = int'(model[(base + j / 8) % DEPTH][7 - (j % 8)]);
        chk(req, "miso_oe driving", int'(miso_oe), 1);
        chk(req, "data bit", int'(miso), e);
        tick(1);
        sclk = 1'b1;
        tick(3);
        chk("R11", "bit held while SCLK high", int'(miso), e);
        tick(1);
        continue;
      end
      tick(1);
      sclk = 1'b1;
      tick(4);
    end
    // chip select release lands in the same cycle as the falling edge
    sclk = 1'b0;
    cs_n = 1'b1;
    busy = 1'b0;
    tick(3);
    chk("R8", "miso_oe after release", int'(miso_oe), 0);
    tick(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    chk("R1", "miso_oe in reset", int'(miso_oe), 0);
    rst_n = 1'b1;
    tick(2);
    chk("R1", "miso_oe after reset", int'(miso_oe), 0);
    chk("R1", "pre_ready after reset", int'(pre_ready), 1);

    for (int a = 0; a < DEPTH; a++) pre_write(a, ((a * 29 + 7) ^ (a >> 3)) & 8'hFF);

    run_cmd(8'h0B, 24'h000010, 32, 0, "R5");  // R5 R6 plain stream
    run_cmd(8'h0B, 24'hAB00FC, 48, 0, "R7");  // R7 wrap, R3 upper bits dropped
    run_cmd(8'h0B, 24'h000000, 16, 1, "R10"); // R10 busy at opcode end
    run_cmd(8'h0B, 24'h000040, 24, 2, "R10"); // R10 busy later has no effect
    run_cmd(8'h03, 24'h000010, 16, 0, "R9");  // R9 unknown opcode
    run_cmd(8'h0B, 24'h000080, 11, 0, "R8");  // R8 abort mid-byte
    run_cmd(8'h0B, 24'h000081, 16, 0, "R8");  // R8 fresh command after abort
    run_cmd(8'h0B, 24'h0000FF, 40, 0, "R6");  // R6 long stream from top

    // R2 preload offered while selected is held off and leaves the array unchanged
    cs_n = 1'b0;
    tick(3);
    pre_valid = 1'b1;
    pre_addr  = AW'(8'h22);
    pre_data  = ~model[8'h22];
    tick(1);
    chk("R2", "pre_ready while selected", int'(pre_ready), 0);
    tick(2);
    pre_valid = 1'b0;
    cs_n = 1'b1;
    tick(4);
    run_cmd(8'h0B, 24'h000022, 8, 0, "R2");
    pre_write(8'h22, 8'h5A);
    run_cmd(8'h0B, 24'h000021, 24, 0, "R2");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule